// File: doc/BRIEF.md
# Input Change Interrupt Generator

This block watches the synchronized levels of a parallel port and flags any pin, set up as an input, whose level no longer matches a snapshot. The snapshot is taken whenever the input register is read. While at least one such pin differs, the block pulls an active-low interrupt line low. The line is modelled as open-drain: an enable pulls it low, and when the enable is off the line floats and an external pull-up holds it high.

The interrupt follows the level, not the edge. If the differing pin returns to its captured value, the interrupt drops without any read. A read pulse reloads the snapshot from the current pins and so also drops the interrupt. Pins set up as outputs never take part. If a pin is switched from output to input while its level disagrees with the snapshot, the interrupt is raised at once. The comparison uses raw pin levels, before any polarity inversion. The snapshot is primed from the pins on the first clock after reset is released. Register access and the pads are outside this block.

Top module: `ioc_irq_gen`

## Requirements
- R1: While rst_n is low, and on the first clock edge after rst_n goes high, irq_n is 1 and irq_oe is 0.
- R2: When a pin with dir_in bit = 1 (input) has a level that differs from its snapshot bit, irq_n is 0 after the next rising clock edge. This holds whether one pin or several pins differ.
- R3: When every input pin matches the snapshot again, irq_n returns to 1 after the next rising edge, with no read pulse needed.
- R4: A rd_pulse of 1 loads the snapshot with the current pin levels. irq_n is 1 after that edge and stays 1 while the pins hold.
- R5: Pins with dir_in bit = 0 (output) never cause irq_n to go low, whatever their level.
- R6: Setting a dir_in bit from 0 to 1 while that pin differs from its snapshot makes irq_n 0 after the next rising edge.
- R7: irq_oe is always the inverse of irq_n: 1 means the line is pulled low.
- R8: On the first rising edge after reset release, the snapshot takes the pin levels present at that edge. Later differences are measured against those levels.
- R9: irq_n and irq_oe change only on rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | WIDTH | Synchronized pin levels |
| dir_in | input | WIDTH | Per-pin direction, 1 = input, 0 = output |
| rd_pulse | input | 1 | One-cycle pulse marking a read of the input register |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Open-drain pull-low enable |

## Verification
Every result here is due exactly one rising edge after the stimulus that causes it. This holds for assert, self-clear, read-clear, the direction change and reset priming, because the only register between the inputs and the interrupt is one flop in the drive stage. The driver applies each stimulus on a falling edge and pushes the expected line state into a queue. The monitor pops the queue 2 ns after the next rising edge, so each compare lands in the cycle in which its result appears and never on the edge itself.

// File: rtl/ioc_pkg.sv
// Package: types shared by the input change interrupt blocks.
// Assumes: nothing beyond IEEE 1800-2017.
package ioc_pkg;
    // Snapshot tracking phase: waiting to prime, or comparing.
    typedef enum logic {
        SNAP_PRIME = 1'b0,
        SNAP_TRACK = 1'b1
    } snap_phase_e;
endpackage

// File: rtl/ioc_snapshot.sv
// Module: holds the captured pin levels that inputs are compared against.
// Assumes: pin_lvl is already synchronized to clk, and rd_pulse lasts one cycle.
// The snapshot is primed from the pins on the first edge after reset.
module ioc_snapshot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic             rd_pulse,
    output logic [WIDTH-1:0] snap,
    output logic             armed
);
    import ioc_pkg::*;

    snap_phase_e phase_q;

    // Purpose: prime once after reset, then reload on every read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= SNAP_PRIME;
            snap    <= '0;
        end else begin
            if (phase_q == SNAP_PRIME || rd_pulse) begin
                snap <= pin_lvl;
            end
            phase_q <= SNAP_TRACK;
        end
    end

    // Purpose: tell the drive stage whether the comparison is meaningful.
    always_comb armed = (phase_q == SNAP_TRACK);
endmodule

// File: rtl/ioc_mismatch.sv
// Module: compares raw pin levels with the snapshot, per bit, masked by direction.
// Assumes: dir bit 1 means input. Purely combinational.
module ioc_mismatch #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic [WIDTH-1:0] snap,
    input  logic [WIDTH-1:0] dir_in,
    output logic             any_diff
);
    logic [WIDTH-1:0] diff_bits;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: flag one input pin whose level disagrees with its snapshot bit.
        always_comb diff_bits[i] = dir_in[i] & (pin_lvl[i] ^ snap[i]);
    end

    // Purpose: reduce the per-pin flags to a single request.
    always_comb any_diff = |diff_bits;
endmodule

// File: rtl/ioc_irq_drive.sv
// Module: registers the interrupt and produces the open-drain style outputs.
// Assumes: a read pulse wins over a mismatch in the same cycle, because the
// snapshot reloads on that same edge.
module ioc_irq_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic any_diff,
    input  logic rd_pulse,
    output logic irq_n,
    output logic irq_oe
);
    logic irq_q;

    // Purpose: hold the interrupt level so it moves only on clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= armed & ~rd_pulse & any_diff;
        end
    end

    // Purpose: drive the pull-low enable and the active-low level.
    always_comb begin
        irq_oe = irq_q;
        irq_n  = ~irq_q;
    end
endmodule

// File: rtl/ioc_irq_gen.sv
// Module: top of the input change interrupt generator.
// Assumes: pins are synchronized upstream, and polarity inversion is applied
// elsewhere (the comparison here uses raw levels).
module ioc_irq_gen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic [WIDTH-1:0] dir_in,
    input  logic             rd_pulse,
    output logic             irq_n,
    output logic             irq_oe
);
    logic [WIDTH-1:0] snap;
    logic             armed;
    logic             any_diff;

    ioc_snapshot #(.WIDTH(WIDTH)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .rd_pulse (rd_pulse),
        .snap     (snap),
        .armed    (armed)
    );

    ioc_mismatch #(.WIDTH(WIDTH)) u_cmp (
        .pin_lvl  (pin_lvl),
        .snap     (snap),
        .dir_in   (dir_in),
        .any_diff (any_diff)
    );

    ioc_irq_drive u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (armed),
        .any_diff (any_diff),
        .rd_pulse (rd_pulse),
        .irq_n    (irq_n),
        .irq_oe   (irq_oe)
    );
endmodule

// File: rtl/ioc_irq_gen_chk.sv
// Module: assertion checker bound to ioc_irq_gen. It observes ports only.
module ioc_irq_gen_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_lvl,
    input logic [WIDTH-1:0] dir_in,
    input logic             rd_pulse,
    input logic             irq_n,
    input logic             irq_oe
);
    // R1: a reset cycle leaves the line released.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> irq_n);

    // R3: with no input activity, an idle line stays idle.
    p_quiet_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && $stable(pin_lvl) && $stable(dir_in)) |=> irq_n);

    // R4: a read releases the line on the next edge.
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> irq_n);

    // R5: with every pin set as output, no interrupt follows.
    p_outputs_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in == '0) |=> irq_n);

    // R7: the pull-low enable and the level agree.
    p_oe_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe == !irq_n);
endmodule

bind ioc_irq_gen ioc_irq_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .dir_in   (dir_in),
    .rd_pulse (rd_pulse),
    .irq_n    (irq_n),
    .irq_oe   (irq_oe)
);

// File: tb/tb_ioc_irq_gen.sv
// Scoreboard bench: the driver pushes the expected irq_n, and the monitor pops
// and compares it 2 ns after the rising edge that produces it.
module tb_ioc_irq_gen;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_lvl = '0;
    logic [W-1:0] dir_in = '1;
    logic         rd_pulse = 1'b0;
    logic         irq_n;
    logic         irq_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_n;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    ioc_irq_gen #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .dir_in   (dir_in),
        .rd_pulse (rd_pulse),
        .irq_n    (irq_n),
        .irq_oe   (irq_oe)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus on a falling edge and queue its expected result.
    task automatic step(input logic rst, input logic [W-1:0] p, input logic [W-1:0] d,
                        input logic rd, input logic exp, input string tag);
        @(negedge clk);
        rst_n    = rst;
        pin_lvl  = p;
        dir_in   = d;
        rd_pulse = rd;
        sb_q.push_back('{exp, tag});
    endtask

    // Monitor: pop and compare after each rising edge; R7 and R9 are checked alongside.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic  hold;
                it = sb_q.pop_front();
                check(irq_n, it.exp_n, it.tag);
                check(irq_oe, ~irq_n, "R7 oe inverse of level");
                hold = irq_n;
                #5;
                check(irq_n, hold, "R9 stable between edges");
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        pin_lvl = 8'hA5;
        repeat (3) @(posedge clk);
        #2;
        check(irq_n, 1'b1, "R1 level in reset");
        check(irq_oe, 1'b0, "R1 oe in reset");

        step(1, 8'hA5, 8'hFF, 0, 1, "R1 first cycle after release");
        step(1, 8'hA5, 8'hFF, 0, 1, "R8 primed to A5");
        step(1, 8'hA4, 8'hFF, 0, 0, "R2 single pin differs");
        step(1, 8'hA4, 8'hFF, 0, 0, "R2 held");
        step(1, 8'hA5, 8'hFF, 0, 1, "R3 self clear");
        step(1, 8'h5A, 8'hFF, 0, 0, "R2 many pins differ");
        step(1, 8'hA4, 8'hFF, 0, 0, "R2 one pin still differs");
        step(1, 8'hA4, 8'hFF, 1, 1, "R4 read clears");
        step(1, 8'hA4, 8'hFF, 0, 1, "R4 snapshot now A4");
        step(1, 8'hA5, 8'hFF, 0, 0, "R4 compare against new snapshot");
        step(1, 8'hA4, 8'hFF, 0, 1, "R3 back to A4");
        step(1, 8'h54, 8'h0F, 0, 1, "R5 output nibble toggled");
        step(1, 8'h5B, 8'h00, 0, 1, "R5 all outputs toggled");
        step(1, 8'hAC, 8'h00, 0, 1, "R5 bit3 differs as output");
        step(1, 8'hAC, 8'h08, 0, 0, "R6 output to input mismatch");
        step(1, 8'hAC, 8'h00, 0, 1, "R5 back to output");
        step(0, 8'h3C, 8'hFF, 0, 1, "R1 reset mid run");
        step(0, 8'h3C, 8'hFF, 0, 1, "R1 reset held");
        step(1, 8'h3C, 8'hFF, 0, 1, "R1 first cycle after release");
        step(1, 8'h3C, 8'hFF, 0, 1, "R8 primed to 3C");
        step(1, 8'h3D, 8'hFF, 0, 0, "R8 differs from primed value");
        step(1, 8'h3D, 8'hFF, 0, 0, "R8 held");

        @(negedge clk);
        rd_pulse = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule